// File: doc/BRIEF.md
# Quad SPI PSRAM Read Engine

This block fetches one 32-bit word from an external pseudo-static RAM over a four-lane SPI bus. A requester presents a 24-bit byte address on a valid/ready request channel. The block then runs a fixed frame of 22 serial clocks. The frame has four phases in order: two clocks for the read command byte, six for the address, six turnaround (wait) clocks, and eight clocks that capture the returned word. The word comes back on a response channel as a single-cycle valid pulse.

The serial clock comes from the system clock through an even divider. Each serial clock lasts `2*DIV_HALF` system clocks. The block puts data out on the falling serial edge and samples data in on the rising edge. It releases the four data lines for the wait and data phases.

The request channel follows valid/ready rules. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is simply the inverse of `busy`, so requests offered during a transaction get no handshake and leave no trace. The response channel has no back-pressure. The requester must accept `rsp_valid` in the cycle it is high, and `rsp_data` is then held until the next response. Chip selection among several devices is done upstream.

Top module: `qspi_word_fetch`

## Requirements
- R1: Each frame sends the command byte (parameter, default 0xEB) and then the 24-bit address, most significant nibble first, one nibble per serial clock on `qspi_io_out[3:0]`, where bit 3 carries the most significant bit of the nibble.
- R2: Each read produces exactly 22 rising serial clock edges: 2 command, 6 address, 6 wait and 8 data clocks.
- R3: Consecutive rising serial edges are `2*DIV_HALF` system clocks apart, so the divider ratio is always even.
- R4: `qspi_io_oe` goes high on the accepting edge and stays high through the eighth serial clock. It falls with the falling edge that ends the eighth clock, which is where the first wait clock begins. It stays low through the data phase and while idle.
- R5: `qspi_cs_n` falls on the accepting edge, one system clock before the first rising serial edge.
- R6: `qspi_cs_n` rises, and `qspi_sclk` returns low, one system clock after the rising edge that captures the last data nibble.
- R7: While chip select is held, `qspi_io_out` changes only together with a falling serial edge. `qspi_io_in` is sampled at rising serial edges.
- R8: `req_ready` equals `!busy`. `busy` rises the cycle after acceptance and falls in the cycle `rsp_valid` is high. A request offered while busy starts no second frame and does not alter the frame in flight.
- R9: `rsp_valid` is high for exactly one system clock per read, and `rsp_data` holds its value until the next response.
- R10: `rsp_valid` is seen `42*DIV_HALF+2` system clocks after the accepting edge.
- R11: `rsp_data` is the eight captured nibbles, the first one in bits 31:28.
- R12: After reset, `qspi_cs_n` is 1, and `qspi_sclk`, `qspi_io_oe`, `busy`, `rsp_valid` and `rsp_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Request can be taken (engine idle) |
| req_addr | input | ADDR_W | Byte address of the word to read |
| rsp_valid | output | 1 | One-cycle pulse: read word available |
| rsp_data | output | DATA_W | Returned word, held until next response |
| busy | output | 1 | Transaction in flight |
| qspi_cs_n | output | 1 | Device select, active low |
| qspi_sclk | output | 1 | Serial clock, idles low |
| qspi_io_out | output | LANES | Data lanes driven toward the device |
| qspi_io_oe | output | 1 | Lane output enable |
| qspi_io_in | input | LANES | Data lanes returned from the device |

## Verification
The case that is hardest to reach from the ports is a request that keeps arriving during a frame. The engine must refuse it without the chip select glitching, without the shifted address being replaced, and without a second response. The stimulus holds `req_valid` high with a different address for forty cycles after acceptance. The bench then checks that only one select fall and one response occur, and that the nibbles seen on the bus still spell the original address. The bench also acts as a device model: after each falling serial edge it drives the next data nibble, so capture on the rising edge is tested with the exact phase a real device gives.

// File: rtl/qfetch_pkg.sv
package qfetch_pkg;

  typedef enum logic [1:0] {
    QF_IDLE = 2'd0,
    QF_LEAD = 2'd1,
    QF_XFER = 2'd2,
    QF_TAIL = 2'd3
  } qf_state_e;

  function automatic int clocks_for(input int bits, input int lanes);
    return (bits + lanes - 1) / lanes;
  endfunction

endpackage

// File: rtl/qfetch_sclk_gen.sv
module qfetch_sclk_gen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  input  logic run,
  input  logic halt,
  output logic sclk,
  output logic rise_now,
  output logic fall_now
);

  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] hcnt;
  logic          sclk_q;
  logic          at_end;

  assign at_end   = (hcnt == CW'(HALF - 1));
  assign rise_now = kick | (run & ~sclk_q & at_end);
  assign fall_now = run & sclk_q & at_end;
  assign sclk     = sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt   <= '0;
      sclk_q <= 1'b0;
    end else if (halt) begin
      hcnt   <= '0;
      sclk_q <= 1'b0;
    end else if (kick) begin
      hcnt   <= '0;
      sclk_q <= 1'b1;
    end else if (run) begin
      if (at_end) begin
        hcnt   <= '0;
        sclk_q <= ~sclk_q;
      end else begin
        hcnt <= hcnt + CW'(1);
      end
    end else begin
      hcnt <= '0;
    end
  end

  // R3: the clock holds its level between half-period boundaries
  p_half_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !at_end && !halt) |=> $stable(sclk_q));

endmodule

// File: rtl/qfetch_shifter.sv
module qfetch_shifter #(
  parameter int OUT_W = 32,
  parameter int IN_W  = 32,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OUT_W-1:0] load_val,
  input  logic             shift_out,
  input  logic             capture,
  input  logic [LANES-1:0] lanes_in,
  output logic [LANES-1:0] lanes_out,
  output logic [IN_W-1:0]  word_in
);

  logic [OUT_W-1:0] out_reg;
  logic [IN_W-1:0]  in_reg;

  assign lanes_out = out_reg[OUT_W-1 -: LANES];
  assign word_in   = in_reg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_reg <= '0;
    end else if (load) begin
      out_reg <= load_val;
    end else if (shift_out) begin
      out_reg <= {out_reg[OUT_W-LANES-1:0], {LANES{1'b0}}};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_reg <= '0;
    end else if (capture) begin
      in_reg <= {in_reg[IN_W-LANES-1:0], lanes_in};
    end
  end

endmodule

// File: rtl/qspi_word_fetch.sv
module qspi_word_fetch
  import qfetch_pkg::*;
#(
  parameter logic [7:0] CMD       = 8'hEB,
  parameter int         ADDR_W    = 24,
  parameter int         DATA_W    = 32,
  parameter int         WAIT_CLKS = 6,
  parameter int         DIV_HALF  = 2,
  parameter int         LANES     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              busy,
  output logic              qspi_cs_n,
  output logic              qspi_sclk,
  output logic [LANES-1:0]  qspi_io_out,
  output logic              qspi_io_oe,
  input  logic [LANES-1:0]  qspi_io_in
);

  localparam int CMD_CLKS   = clocks_for(8, LANES);
  localparam int ADDR_CLKS  = clocks_for(ADDR_W, LANES);
  localparam int DATA_CLKS  = clocks_for(DATA_W, LANES);
  localparam int DRIVE_CLKS = CMD_CLKS + ADDR_CLKS;
  localparam int CAP_FIRST  = DRIVE_CLKS + WAIT_CLKS;
  localparam int TOTAL_CLKS = CAP_FIRST + DATA_CLKS;
  localparam int IW         = $clog2(TOTAL_CLKS + 1);
  localparam int OUT_W      = 8 + ADDR_W;

  qf_state_e   state;
  logic [IW-1:0] clk_idx;
  logic        cs_n_q;
  logic        oe_q;
  logic        accept;
  logic        kick, run, halt;
  logic        rise_now, fall_now;
  logic        cap_en, last_cap;
  logic [DATA_W-1:0] cap_word;

  assign busy      = (state != QF_IDLE);
  assign req_ready = ~busy;
  assign accept    = req_valid & req_ready;
  assign kick      = (state == QF_LEAD);
  assign run       = (state == QF_XFER);
  assign halt      = (state == QF_TAIL);
  assign cap_en    = run & rise_now & (clk_idx >= IW'(CAP_FIRST));
  assign last_cap  = cap_en & (clk_idx == IW'(TOTAL_CLKS - 1));
  assign qspi_cs_n  = cs_n_q;
  assign qspi_io_oe = oe_q;

  qfetch_sclk_gen #(.HALF(DIV_HALF)) u_sclk (
    .clk      (clk),
    .rst_n    (rst_n),
    .kick     (kick),
    .run      (run),
    .halt     (halt),
    .sclk     (qspi_sclk),
    .rise_now (rise_now),
    .fall_now (fall_now)
  );

  qfetch_shifter #(.OUT_W(OUT_W), .IN_W(DATA_W), .LANES(LANES)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_val  ({CMD, req_addr}),
    .shift_out (fall_now),
    .capture   (cap_en),
    .lanes_in  (qspi_io_in),
    .lanes_out (qspi_io_out),
    .word_in   (cap_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= QF_IDLE;
      cs_n_q    <= 1'b1;
      oe_q      <= 1'b0;
      clk_idx   <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        QF_IDLE: begin
          if (accept) begin
            state   <= QF_LEAD;
            cs_n_q  <= 1'b0;
            oe_q    <= 1'b1;
            clk_idx <= '0;
          end
        end
        QF_LEAD: begin
          state   <= QF_XFER;
          clk_idx <= '0;
        end
        QF_XFER: begin
          if (fall_now) begin
            clk_idx <= clk_idx + IW'(1);
            if (clk_idx == IW'(DRIVE_CLKS - 1)) oe_q <= 1'b0;
          end
          if (last_cap) state <= QF_TAIL;
        end
        QF_TAIL: begin
          cs_n_q    <= 1'b1;
          oe_q      <= 1'b0;
          rsp_valid <= 1'b1;
          rsp_data  <= cap_word;
          state     <= QF_IDLE;
        end
        default: state <= QF_IDLE;
      endcase
    end
  end

  // R2: the frame counter never passes the last serial clock
  p_frame_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == QF_XFER) |-> (clk_idx < IW'(TOTAL_CLKS)));

  // R4: lanes are driven only during command and address clocks
  p_lines_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (qspi_io_oe && state == QF_XFER) |-> (clk_idx < IW'(DRIVE_CLKS)));

  // R5: select leads the first serial edge by one system clock
  p_cs_lead_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(qspi_cs_n) |=> $rose(qspi_sclk));

  // R7: driven data moves only with a falling serial edge
  p_edge_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!qspi_cs_n && !$past(qspi_cs_n) && !$stable(qspi_io_out)) |-> $fell(qspi_sclk));

  // R8: busy begins together with the select falling
  p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $fell(qspi_cs_n));

  // R9: the response pulse is a single cycle
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R9: the returned word holds between responses
  p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> $stable(rsp_data));

endmodule

// File: tb/qspi_word_fetch_test.sv
`timescale 1ns/1ps
module qspi_word_fetch_test;

  localparam int         HALF    = 2;
  localparam logic [7:0] CMD     = 8'hEB;
  localparam int         NFRAME  = 22;
  localparam int         LATENCY = 42 * HALF + 2;
  localparam int         NVEC    = 6;

  // {spam, address, device word}
  localparam logic [56:0] VEC [NVEC] = '{
    {1'b0, 24'h000000, 32'h00000000},
    {1'b0, 24'hFFFFFF, 32'hFFFFFFFF},
    {1'b0, 24'h123456, 32'h89ABCDEF},
    {1'b1, 24'hA5C3E1, 32'h5A5A0FF0},
    {1'b0, 24'h800001, 32'h80000001},
    {1'b1, 24'h0F0F0F, 32'hDEADBEEF}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        busy;
  logic        qspi_cs_n;
  logic        qspi_sclk;
  logic [3:0]  qspi_io_out;
  logic        qspi_io_oe;
  logic [3:0]  qspi_io_in = '0;

  always #4 clk = ~clk;

  qspi_word_fetch #(.CMD(CMD), .DIV_HALF(HALF)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy),
    .qspi_cs_n(qspi_cs_n), .qspi_sclk(qspi_sclk),
    .qspi_io_out(qspi_io_out), .qspi_io_oe(qspi_io_oe), .qspi_io_in(qspi_io_in)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bus monitor and device model
  logic [3:0]  nib  [32];
  logic        oes  [32];
  int          trise[32];
  int          nr = 0, nrsp = 0, ncsf = 0;
  int          t_csf = 0, t_csr = 0, t_rsp = 0;
  logic [31:0] got = '0, cur_word = '0;
  logic        sclk_p = 1'b0, cs_p = 1'b1;

  always @(negedge clk) begin
    if (cs_p && !qspi_cs_n) begin t_csf = cyc; ncsf++; end
    if (!cs_p && qspi_cs_n) t_csr = cyc;
    if (qspi_sclk && !sclk_p) begin
      if (nr < 32) begin
        nib[nr] = qspi_io_out; oes[nr] = qspi_io_oe; trise[nr] = cyc;
      end
      nr++;
    end
    if (!qspi_sclk && sclk_p) begin
      if (nr >= 14 && nr < NFRAME) qspi_io_in = cur_word[(21 - nr) * 4 +: 4];
      else qspi_io_in = '0;
    end
    if (rsp_valid) begin nrsp++; t_rsp = cyc; got = rsp_data; end
    sclk_p = qspi_sclk;
    cs_p   = qspi_cs_n;
  end

  task automatic run_read(input logic [23:0] addr, input logic [31:0] word, input bit spam);
    int t_acc;
    cur_word = word; nr = 0; nrsp = 0; ncsf = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr;
    @(negedge clk);
    t_acc = cyc;
    req_valid = spam; req_addr = ~addr;
    if (spam) chk(busy && !req_ready, "R8", "busy/ready while in flight", {busy, req_ready}, 2'b10);
    for (int i = 0; i < 40; i++) @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 400 && nrsp == 0; i++) @(posedge clk);
    for (int i = 0; i < 6; i++) @(posedge clk);
    @(negedge clk);
    chk(nr == NFRAME, "R2", "rising serial edges", nr, NFRAME);
    chk(ncsf == 1 && nrsp == 1, "R8", "selects/responses per request", {ncsf[7:0], nrsp[7:0]}, 16'h0101);
    chk(nib[0] == CMD[7:4] && nib[1] == CMD[3:0], "R1", "command nibbles", {nib[0], nib[1]}, CMD);
    chk({nib[2], nib[3], nib[4], nib[5], nib[6], nib[7]} == addr, "R1", "address nibbles",
        {nib[2], nib[3], nib[4], nib[5], nib[6], nib[7]}, addr);
    for (int k = 0; k < NFRAME; k++)
      chk(oes[k] == (k < 8), "R4", $sformatf("lane enable at clock %0d", k), oes[k], k < 8);
    for (int k = 1; k < NFRAME; k++)
      chk(trise[k] - trise[k-1] == 2 * HALF, "R3", $sformatf("period before clock %0d", k),
          trise[k] - trise[k-1], 2 * HALF);
    chk(t_csf == t_acc && trise[0] - t_csf == 1, "R5", "select lead",
        trise[0] - t_csf, 1);
    chk(t_csr - trise[NFRAME-1] == 1 && !qspi_sclk, "R6", "select trail",
        t_csr - trise[NFRAME-1], 1);
    chk(t_rsp - t_acc == LATENCY, "R10", "response latency", t_rsp - t_acc, LATENCY);
    chk(got == word, "R11", "returned word", got, word);
    chk(rsp_data == word && !rsp_valid && !busy, "R9", "word held after pulse", rsp_data, word);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(qspi_cs_n && !qspi_sclk && !qspi_io_oe && !busy && !rsp_valid && rsp_data == '0,
        "R12", "reset state",
        {qspi_cs_n, qspi_sclk, qspi_io_oe, busy, rsp_valid, |rsp_data}, 6'b100000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !busy, "R8", "ready when idle", req_ready, 1);
    // R7 is checked through R1 and R11: nibbles sampled at rising edges match
    for (int v = 0; v < NVEC; v++) begin
      run_read(VEC[v][55:32], VEC[v][31:0], VEC[v][56]);
    end
    // R9 directed: word from the last read is unchanged many cycles later
    repeat (50) @(posedge clk);
    @(negedge clk);
    chk(rsp_data == VEC[NVEC-1][31:0], "R9", "word held while idle", rsp_data, VEC[NVEC-1][31:0]);
    // R12 directed: reset mid-frame returns to idle outputs
    req_valid = 1'b1; req_addr = 24'h55AA55;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(qspi_cs_n && !qspi_sclk && !qspi_io_oe && !busy && rsp_data == '0,
        "R12", "reset during frame",
        {qspi_cs_n, qspi_sclk, qspi_io_oe, busy, |rsp_data}, 5'b10000);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule